// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a periodic down-counter behind a small register port. Software writes a start value into a reload register, clears the live count, and turns the counter on through a control register. From then on the count drops by one on every active tick. A tick is either every core clock cycle or each cycle in which an external tick-enable input is high. When the count is at zero, the next tick loads the reload value again, so the timer repeats with a period of reload + 1 ticks.

Each step from one to zero sets a sticky event flag. If interrupts are enabled, the same step also raises a level interrupt request. The flag clears when software reads the control register. The interrupt stays high until a separate acknowledge input is pulsed. The register port is single-cycle: writes take effect at the clock edge, and read data is combinational from the current register state.

Top module: `tick_timer`

## Requirements
- R1: Reset clears the control, reload and count registers, the event flag and the interrupt request. With control bit 0 low the count does not change, even when a reload value is present.
- R2: The reload register (word address 1) keeps only write bits 23:0. Bits 31:24 are ignored and read back as zero.
- R3: While enabled, each tick lowers a nonzero count by one, and a count of zero loads the reload value. After enabling from zero with reload N, the count reads N, N-1, ..., 0, N, ... on successive ticks.
- R4: Control bit 2 selects the tick source. With bit 2 = 1 every clock cycle is a tick. With bit 2 = 0, only cycles in which `ext_tick` is high are ticks.
- R5: Any write to the count register (word address 2) sets the count to zero, whatever the data. The same write clears the event flag.
- R6: The control register (word address 0) holds enable in bit 0, interrupt enable in bit 1 and source select in bit 2, and reads them back in those positions. Bit 16 reads the event flag and ignores writes. All other bits read zero.
- R7: The event flag sets on a tick that moves the count from 1 to 0. A read of the control register returns the flag and clears it, so a second read returns 0.
- R8: When control bit 1 is set, a 1-to-0 step raises `irq`. `irq` then stays high until `irq_clear` is pulsed; a new event in the same cycle as the acknowledge wins. When bit 1 is clear, `irq` stays low.
- R9: A reload value of zero keeps the count at zero. No flag and no interrupt follow.
- R10: A read of the count register returns the live count in bits 23:0, with zeros in bits 31:24.
- R11: Word address 3 is unused. It reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (2) | Word address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the addressed register |
| ext_tick | input | 1 | External tick enable, used when control bit 2 is 0 |
| irq_clear | input | 1 | Acknowledge that drops the interrupt request |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume a synchronous environment. Every input is stable around the rising edge, and `bus_wr` is meaningful only while `bus_sel` is high. The counting properties also assume that a tick and a count-register write never interfere in a way other than the write winning, which the design enforces. The stimulus drives every input on the falling edge. It issues one access at a time and holds `bus_sel` high through several cycles only for reads of the count register, which have no side effect. It pulses `irq_clear` only while the counter is stopped, so each expected count follows from the number of ticks alone.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   // Word addresses of the register port
   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_RELOAD = 2'd1,
      REG_VALUE  = 2'd2,
      REG_NONE   = 2'd3
   } reg_sel_e;

   // Bit positions inside the control word
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_IE_BIT   = 1;
   localparam int CTRL_SRC_BIT  = 2;
   localparam int CTRL_FLAG_BIT = 16;

   // Writable control bits, packed msb first: {src, ie, en}
   typedef struct packed {
      logic src;
      logic ie;
      logic en;
   } ctrl_t;

endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
   import tick_timer_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int COUNT_W = 24,
   parameter int ADDR_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [COUNT_W-1:0] cur_count,
   input  logic               flag,
   output ctrl_t              ctrl_q,
   output logic [COUNT_W-1:0] reload_q,
   output logic               value_wr,
   output logic               ctrl_rd
);

   localparam int PAD_W = DATA_W - COUNT_W;

   reg_sel_e          sel;
   logic              ctrl_wr;
   logic              reload_wr;
   logic [DATA_W-1:0] count_ext;
   logic [DATA_W-1:0] reload_ext;

   // Address decode
   always_comb begin
      if (bus_addr == ADDR_W'(REG_CTRL))        sel = REG_CTRL;
      else if (bus_addr == ADDR_W'(REG_RELOAD)) sel = REG_RELOAD;
      else if (bus_addr == ADDR_W'(REG_VALUE))  sel = REG_VALUE;
      else                                      sel = REG_NONE;
   end

   assign ctrl_wr   = bus_sel &  bus_wr & (sel == REG_CTRL);
   assign reload_wr = bus_sel &  bus_wr & (sel == REG_RELOAD);
   assign value_wr  = bus_sel &  bus_wr & (sel == REG_VALUE);
   assign ctrl_rd   = bus_sel & ~bus_wr & (sel == REG_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else begin
         if (ctrl_wr)
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_SRC_BIT:CTRL_EN_BIT]);
         if (reload_wr)
            reload_q <= bus_wdata[COUNT_W-1:0];
      end
   end

   // Zero padding of count-wide fields up to the data width
   generate
      if (PAD_W > 0) begin : g_pad
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[DATA_W-1:COUNT_W];
         assign count_ext  = {{PAD_W{1'b0}}, cur_count};
         assign reload_ext = {{PAD_W{1'b0}}, reload_q};
      end else begin : g_nopad
         assign count_ext  = cur_count;
         assign reload_ext = reload_q;
      end
   endgenerate

   // Read data mux
   always_comb begin
      bus_rdata = '0;
      case (sel)
         REG_CTRL: begin
            bus_rdata[CTRL_SRC_BIT:CTRL_EN_BIT] = ctrl_q;
            bus_rdata[CTRL_FLAG_BIT]            = flag;
         end
         REG_RELOAD: bus_rdata = reload_ext;
         REG_VALUE:  bus_rdata = count_ext;
         default:    bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
   parameter int COUNT_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               clear,
   input  logic               flag_rd,
   input  logic [COUNT_W-1:0] reload,
   output logic [COUNT_W-1:0] cur_count,
   output logic               zero_evt,
   output logic               flag
);

   localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

   // A tick that steps the count from one to zero, unless a write clears it first
   assign zero_evt = tick & ~clear & (cur_count == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_count <= '0;
      end else if (clear) begin
         cur_count <= '0;
      end else if (tick) begin
         if (cur_count == '0) cur_count <= reload;
         else                 cur_count <= cur_count - ONE;
      end
   end

   // Sticky event flag: a set in the same cycle as a read wins
   always_ff @(posedge clk) begin
      if (!rst_n)                flag <= 1'b0;
      else if (zero_evt)         flag <= 1'b1;
      else if (flag_rd || clear) flag <= 1'b0;
   end

endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic irq
);

   always_ff @(posedge clk) begin
      if (!rst_n)   irq <= 1'b0;
      else if (set) irq <= 1'b1;
      else if (ack) irq <= 1'b0;
   end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int COUNT_W      = 24,
   parameter int ADDR_W       = 2,
   parameter bit HAS_EXT_TICK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ext_tick,
   input  logic              irq_clear,
   output logic              irq
);

   // Elaboration checks
   generate
      if (COUNT_W < 2 || COUNT_W > DATA_W) begin : g_bad_count
         $error("tick_timer: COUNT_W must lie between 2 and DATA_W");
      end
      if (DATA_W <= CTRL_FLAG_BIT) begin : g_bad_data
         $error("tick_timer: DATA_W too narrow for the event flag bit");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("tick_timer: ADDR_W must be at least 2");
      end
   endgenerate

   ctrl_t              ctrl_q;
   logic [COUNT_W-1:0] reload_q;
   logic [COUNT_W-1:0] cur_count;
   logic               value_wr;
   logic               ctrl_rd;
   logic               flag;
   logic               zero_evt;
   logic               tick;
   logic               src_tick;
   logic               irq_en;

   assign irq_en = ctrl_q.ie;

   // Tick source: external enable or core clock, chosen per instance
   generate
      if (HAS_EXT_TICK) begin : g_ext_src
         assign src_tick = ctrl_q.src | ext_tick;
      end else begin : g_core_only
         logic unused_ext;
         assign unused_ext = ext_tick ^ ctrl_q.src;
         assign src_tick   = 1'b1;
      end
   endgenerate

   assign tick = ctrl_q.en & src_tick;

   tick_timer_regs #(
      .DATA_W  (DATA_W),
      .COUNT_W (COUNT_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cur_count (cur_count),
      .flag      (flag),
      .ctrl_q    (ctrl_q),
      .reload_q  (reload_q),
      .value_wr  (value_wr),
      .ctrl_rd   (ctrl_rd)
   );

   tick_timer_core #(
      .COUNT_W (COUNT_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .clear     (value_wr),
      .flag_rd   (ctrl_rd),
      .reload    (reload_q),
      .cur_count (cur_count),
      .zero_evt  (zero_evt),
      .flag      (flag)
   );

   tick_timer_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (zero_evt & irq_en),
      .ack   (irq_clear),
      .irq   (irq)
   );

endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
   parameter int COUNT_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               value_wr,
   input logic [COUNT_W-1:0] cur_count,
   input logic [COUNT_W-1:0] reload_q,
   input logic               irq,
   input logic               irq_clear,
   input logic               irq_en,
   input logic               flag
);

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !value_wr) |=> $stable(cur_count));

   assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !value_wr && cur_count != '0) |=> cur_count == COUNT_W'($past(cur_count) - 1'b1));

   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !value_wr && cur_count == '0) |=> cur_count == $past(reload_q));

   assert_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      value_wr |=> (cur_count == '0 && !flag));

   assert_flag_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> cur_count == '0);

   assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (cur_count == '0 && $past(irq_en)));

   assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clear) |=> irq);

endmodule

bind tick_timer tick_timer_checker #(.COUNT_W(COUNT_W)) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .value_wr  (value_wr),
   .cur_count (cur_count),
   .reload_q  (reload_q),
   .irq       (irq),
   .irq_clear (irq_clear),
   .irq_en    (irq_en),
   .flag      (flag)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ext_tick = 1'b0;
   logic        irq_clear = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tick_timer i_tick_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ext_tick  (ext_tick),
      .irq_clear (irq_clear),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called just after a falling edge; returns just after the next one
   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // Count after k ticks, starting from zero, with reload n
   function automatic int unsigned exp_cnt(input int unsigned n, input int unsigned k);
      if (k == 0) return 0;
      return n - ((k - 1) % (n + 1));
   endfunction

   initial begin
      #1600000;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd_reg(2'd0, v); check("R1 ctrl after reset", v, 32'h0);
      rd_reg(2'd1, v); check("R1 reload after reset", v, 32'h0);
      rd_reg(2'd2, v); check("R1 count after reset", v, 32'h0);
      check("R1 irq after reset", {31'b0, irq}, 32'h0);
      wr_reg(2'd1, 32'd5);
      repeat (10) @(negedge clk);
      rd_reg(2'd2, v); check("R1 no count while disabled", v, 32'h0);

      // R11: unused address
      wr_reg(2'd3, 32'hFFFF_FFFF);
      rd_reg(2'd3, v); check("R11 unused address reads zero", v, 32'h0);
      rd_reg(2'd1, v); check("R11 reload untouched", v, 32'd5);
      rd_reg(2'd0, v); check("R11 ctrl untouched", v, 32'h0);

      // R6: control bit positions, flag bit read-only
      wr_reg(2'd0, 32'h0001_0006);
      rd_reg(2'd0, v); check("R6 ctrl readback", v, 32'h0000_0006);
      wr_reg(2'd0, 32'h0);

      // R2: reload width
      wr_reg(2'd1, 32'hFFFF_FFFF);
      rd_reg(2'd1, v); check("R2 reload upper bits dropped", v, 32'h00FF_FFFF);

      // R3, R4, R7, R8: sweep of reload values on the core clock
      for (int n = 1; n <= 6; n++) begin
         wr_reg(2'd2, 32'h0);
         wr_reg(2'd1, n);
         wr_reg(2'd0, 32'h7);
         bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2;
         for (int j = 0; j <= 2 * n + 3; j++) begin
            #1;
            check("R3 count sequence", bus_rdata, exp_cnt(n, j));
            check("R8 irq raised at first zero", {31'b0, irq}, (j >= n + 1) ? 32'h1 : 32'h0);
            @(negedge clk);
         end
         bus_sel = 1'b0;
         wr_reg(2'd0, 32'h0);
         rd_reg(2'd0, v); check("R7 flag set after zero", v, 32'h0001_0000);
         rd_reg(2'd0, v); check("R7 flag cleared by read", v, 32'h0);
         repeat (3) @(negedge clk);
         check("R8 irq held until ack", {31'b0, irq}, 32'h1);
         irq_clear = 1'b1;
         @(negedge clk);
         irq_clear = 1'b0;
         check("R8 irq dropped by ack", {31'b0, irq}, 32'h0);
      end

      // R4: external tick source, interrupts off
      wr_reg(2'd2, 32'h0);
      wr_reg(2'd1, 32'd5);
      wr_reg(2'd0, 32'h1);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2;
      begin
         int k;
         k = 0;
         for (int c = 0; c < 24; c++) begin
            logic pat;
            #1;
            check("R4 count follows ext_tick", bus_rdata, exp_cnt(5, k));
            check("R8 no irq with ie clear", {31'b0, irq}, 32'h0);
            pat = (c % 3) != 1;
            ext_tick = pat;
            @(negedge clk);
            if (pat) k++;
         end
      end
      ext_tick = 1'b0;
      bus_sel = 1'b0;
      wr_reg(2'd0, 32'h0);
      rd_reg(2'd0, v);

      // R5: write to count register clears count and flag
      wr_reg(2'd2, 32'h0);
      wr_reg(2'd1, 32'd9);
      wr_reg(2'd0, 32'h5);
      repeat (12) @(negedge clk);
      wr_reg(2'd0, 32'h0);
      rd_reg(2'd2, v); check("R3 frozen count after 13 ticks", v, 32'd7);
      wr_reg(2'd2, 32'hDEAD_BEEF);
      rd_reg(2'd2, v); check("R5 count cleared by write", v, 32'h0);
      rd_reg(2'd0, v); check("R5 flag cleared by count write", v, 32'h0);

      // R9: reload of zero
      wr_reg(2'd1, 32'h0);
      wr_reg(2'd0, 32'h7);
      repeat (20) @(negedge clk);
      check("R9 no irq with zero reload", {31'b0, irq}, 32'h0);
      rd_reg(2'd2, v); check("R9 count stays zero", v, 32'h0);
      wr_reg(2'd0, 32'h0);
      rd_reg(2'd0, v); check("R9 no flag with zero reload", v, 32'h0);

      // R10: live count read with upper bits zero
      wr_reg(2'd1, 32'hFFFF_FFFF);
      wr_reg(2'd0, 32'h5);
      repeat (2) @(negedge clk);
      rd_reg(2'd2, v); check("R10 live count upper bits zero", v, 32'h00FF_FFFE);
      wr_reg(2'd0, 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule